// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a virtual address into a physical mapping when the translation buffer misses. It holds the base of the first-level table in a register that software writes. It reads descriptor words from memory through a single-word read request/response port and follows at most two table levels. A first-level section entry ends the walk at once. A first-level entry that points to a coarse or a fine second-level table leads to one more fetch, which yields a large, small or tiny page.

A completed walk reports the physical address, a size code, the domain and the access-permission bits, ready to fill a buffer entry. A descriptor whose type is invalid ends the walk with a fault and reports which level faulted. Permission checking and caching of results are done elsewhere. The walker handles one request at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy_o, done_o, fault_o and mem_req_o are all low.
- R2: A base write (base_we_i) keeps base_wdata_i[31:14]. An accepted request fetches the first-level word at {base[31:14], va[31:20], 2'b00}. A base write made while a walk runs leaves the addresses of that walk unchanged and applies from the next request.
- R3: A first-level descriptor with bits[1:0]=00 ends the walk with fault_o and fault_lvl_o=0, and makes no second fetch.
- R4: A first-level descriptor with bits[1:0]=10 is a section. done_o reports pa_o={d[31:20], va[19:0]}, size_o=00, domain_o=d[8:5] and ap_o={4{d[11:10]}}.
- R5: A first-level descriptor with bits[1:0]=01 is a coarse table. The second fetch address is {d[31:10], va[19:12], 2'b00}.
- R6: A first-level descriptor with bits[1:0]=11 is a fine table. The second fetch address is {d[31:12], va[19:10], 2'b00}.
- R7: A second-level descriptor p with bits[1:0]=01 is a large page: pa_o={p[31:16], va[15:0]} and size_o=01. With 10 it is a small page: pa_o={p[31:12], va[11:0]} and size_o=10. With 11 it is a tiny page: pa_o={p[31:10], va[9:0]} and size_o=11.
- R8: For page mappings, domain_o is bits[8:5] of the first-level descriptor. ap_o is p[11:4] for large and small pages and {4{p[5:4]}} for tiny pages.
- R9: A second-level descriptor with bits[1:0]=00 ends the walk with fault_o and fault_lvl_o=1.
- R10: A request is taken only while busy_o is low. busy_o stays high until a single-cycle done_o or fault_o, and never both. busy_o is low in the cycle after that pulse. Each fetch is a one-cycle mem_req_o pulse, and the walker waits for mem_rvalid_i whatever the memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Write enable for the table base register |
| base_wdata_i | input | 32 | New table base; bits 31:14 are kept |
| req_valid_i | input | 1 | Start a walk (taken while busy_o is low) |
| req_va_i | input | 32 | Virtual address to translate |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | One-cycle descriptor read request |
| mem_addr_o | output | 32 | Descriptor word address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor word |
| done_o | output | 1 | One-cycle pulse: translation valid |
| fault_o | output | 1 | One-cycle pulse: translation fault |
| fault_lvl_o | output | 1 | Faulting level (0 first, 1 second) |
| pa_o | output | 32 | Physical address |
| size_o | output | 2 | 00 section, 01 large, 10 small, 11 tiny |
| domain_o | output | 4 | Domain number |
| ap_o | output | 8 | Four 2-bit permission fields |

## Verification
The table geometry comes from the package and is fixed, so the bench uses that single build. It varies the memory response delay from zero to several cycles, which tests the wait states. It places descriptors at both ends of a fine table and of the first-level table, so the index slicing is tested at index zero and at the all-ones index. It moves the base while a walk runs and then walks again, which shows that the old base applies to the running walk and the new base to the next one.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned AW      = 32;
  localparam int unsigned L1_IDX  = 12;
  localparam int unsigned BASE_W  = AW - L1_IDX - 2;
  localparam int unsigned DOM_W   = 4;
  localparam int unsigned SUBPG   = 4;
  localparam int unsigned AP_W    = 2 * SUBPG;

  typedef enum logic [1:0] {
    L1_FAULT = 2'b00, L1_COARSE = 2'b01, L1_SECTION = 2'b10, L1_FINE = 2'b11
  } l1_kind_e;

  typedef enum logic [1:0] {
    SZ_SECTION = 2'b00, SZ_LARGE = 2'b01, SZ_SMALL = 2'b10, SZ_TINY = 2'b11
  } map_size_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
  } walk_st_e;
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  logic [AW-1:0]    desc_i,
  input  logic [AW-1:0]    va_i,
  output l1_kind_e         kind_o,
  output logic [AW-1:0]    l2_addr_o,
  output logic [AW-1:0]    sec_pa_o,
  output logic [DOM_W-1:0] dom_o,
  output logic [AP_W-1:0]  sec_ap_o
);
  assign kind_o = l1_kind_e'(desc_i[1:0]);
  assign dom_o  = desc_i[8:5];
  assign sec_pa_o = {desc_i[31:20], va_i[19:0]};

  for (genvar g = 0; g < SUBPG; g++) begin : g_ap
    assign sec_ap_o[2*g +: 2] = desc_i[11:10];
  end

  // fine tables index 4x more entries than coarse ones
  always_comb begin
    if (desc_i[1:0] == L1_FINE) l2_addr_o = {desc_i[31:12], va_i[19:10], 2'b00};
    else                        l2_addr_o = {desc_i[31:10], va_i[19:12], 2'b00};
  end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [AW-1:0]   desc_i,
  input  logic [AW-1:0]   va_i,
  output logic            fault_o,
  output map_size_e       size_o,
  output logic [AW-1:0]   pa_o,
  output logic [AP_W-1:0] ap_o
);
  logic [AP_W-1:0] tiny_ap;

  for (genvar g = 0; g < SUBPG; g++) begin : g_tap
    assign tiny_ap[2*g +: 2] = desc_i[5:4];
  end

  assign fault_o = (desc_i[1:0] == 2'b00);
  assign size_o  = map_size_e'(desc_i[1:0]);

  always_comb begin
    unique case (desc_i[1:0])
      2'b01:   begin pa_o = {desc_i[31:16], va_i[15:0]}; ap_o = desc_i[11:4]; end
      2'b10:   begin pa_o = {desc_i[31:12], va_i[11:0]}; ap_o = desc_i[11:4]; end
      2'b11:   begin pa_o = {desc_i[31:10], va_i[9:0]};  ap_o = tiny_ap;      end
      default: begin pa_o = '0;                          ap_o = '0;           end
    endcase
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_we_i,
  input  logic [AW-1:0]    base_wdata_i,
  input  logic             req_valid_i,
  input  logic [AW-1:0]    req_va_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             done_o,
  output logic             fault_o,
  output logic             fault_lvl_o,
  output logic [AW-1:0]    pa_o,
  output logic [1:0]       size_o,
  output logic [DOM_W-1:0] domain_o,
  output logic [AP_W-1:0]  ap_o
);
  walk_st_e         state_q;
  logic [BASE_W-1:0] base_q;
  logic [AW-1:0]    va_q, addr_q, pa_q;
  logic [DOM_W-1:0] dom_q;
  logic [AP_W-1:0]  ap_q;
  map_size_e        size_q;
  logic             flvl_q;

  l1_kind_e         l1_kind;
  logic [AW-1:0]    l1_l2addr, l1_pa;
  logic [DOM_W-1:0] l1_dom;
  logic [AP_W-1:0]  l1_ap;
  logic             l2_fault;
  map_size_e        l2_size;
  logic [AW-1:0]    l2_pa;
  logic [AP_W-1:0]  l2_ap;

  ptw_l1_decode u_l1 (
    .desc_i(mem_rdata_i), .va_i(va_q), .kind_o(l1_kind), .l2_addr_o(l1_l2addr),
    .sec_pa_o(l1_pa), .dom_o(l1_dom), .sec_ap_o(l1_ap)
  );

  ptw_l2_decode u_l2 (
    .desc_i(mem_rdata_i), .va_i(va_q), .fault_o(l2_fault), .size_o(l2_size),
    .pa_o(l2_pa), .ap_o(l2_ap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (base_we_i) base_q <= base_wdata_i[AW-1 -: BASE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      dom_q   <= '0;
      ap_q    <= '0;
      size_q  <= SZ_SECTION;
      flvl_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          addr_q  <= {base_q, req_va_i[AW-1 -: L1_IDX], 2'b00};
          state_q <= ST_L1_REQ;
        end
        ST_L1_REQ: state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rvalid_i) begin
          dom_q <= l1_dom;
          unique case (l1_kind)
            L1_FAULT: begin flvl_q <= 1'b0; state_q <= ST_FAULT; end
            L1_SECTION: begin
              pa_q <= l1_pa; ap_q <= l1_ap; size_q <= SZ_SECTION;
              state_q <= ST_DONE;
            end
            default: begin addr_q <= l1_l2addr; state_q <= ST_L2_REQ; end
          endcase
        end
        ST_L2_REQ: state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rvalid_i) begin
          if (l2_fault) begin
            flvl_q  <= 1'b1;
            state_q <= ST_FAULT;
          end else begin
            pa_q <= l2_pa; ap_q <= l2_ap; size_q <= l2_size;
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_addr_o  = addr_q;
  assign done_o      = (state_q == ST_DONE);
  assign fault_o     = (state_q == ST_FAULT);
  assign fault_lvl_o = flvl_q;
  assign pa_o        = pa_q;
  assign size_o      = size_q;
  assign domain_o    = dom_q;
  assign ap_o        = ap_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import ptw_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            busy_o,
  input logic            mem_req_o,
  input logic            done_o,
  input logic            fault_o,
  input logic [AW-1:0]   pa_o,
  input logic [1:0]      size_o,
  input logic [AP_W-1:0] ap_o,
  input logic [AW-1:0]   va_q
);
  AST_RESULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o)); // R10
  AST_RESULT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> busy_o); // R10
  AST_RESULT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> (!busy_o && !done_o && !fault_o)); // R10
  AST_FETCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R10
  AST_FETCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R10
  AST_START_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (mem_req_o && $past(req_valid_i))); // R2
  AST_SECTION_OFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && size_o == 2'b00) |-> (pa_o[19:0] == va_q[19:0])); // R4
  AST_SMALL_OFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && size_o == 2'b10) |-> (pa_o[11:0] == va_q[11:0])); // R7
  AST_TINY_AP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && size_o == 2'b11) |-> (ap_o == {SUBPG{ap_o[1:0]}})); // R8
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .busy_o(busy_o),
  .mem_req_o(mem_req_o), .done_o(done_o), .fault_o(fault_o), .pa_o(pa_o),
  .size_o(size_o), .ap_o(ap_o), .va_q(va_q)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        busy, mem_req, done, fault, flvl;
  logic [31:0] mem_addr, pa;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  size;
  logic [3:0]  dom;
  logic [7:0]  ap;

  int n_chk = 0, n_fail = 0;
  int lat = 0;
  logic [31:0] tb_base = '0;
  logic [31:0] mem [logic [31:0]];

  typedef struct packed {
    logic flt; logic lvl; logic [31:0] pa; logic [1:0] sz; logic [3:0] dom; logic [7:0] ap;
  } exp_t;
  typedef struct packed { logic [31:0] addr; logic [1:0] kind; } fetch_t;
  exp_t   exp_q[$];
  fetch_t fetch_q[$];

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .base_we_i(base_we), .base_wdata_i(base_wdata),
    .req_valid_i(req_valid), .req_va_i(req_va), .busy_o(busy), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .fault_lvl_o(flvl), .pa_o(pa), .size_o(size),
    .domain_o(dom), .ap_o(ap)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // reference walk built from the requirements
  task automatic predict(input logic [31:0] va);
    logic [31:0] a1, d1, a2, d2;
    exp_t e;
    e = '0;
    a1 = {tb_base[31:14], va[31:20], 2'b00};
    fetch_q.push_back({a1, 2'd0});
    d1 = rd(a1);
    e.dom = d1[8:5];
    if (d1[1:0] == 2'b00) begin
      e.flt = 1'b1; e.lvl = 1'b0;
    end else if (d1[1:0] == 2'b10) begin
      e.pa = {d1[31:20], va[19:0]}; e.sz = 2'b00; e.ap = {4{d1[11:10]}};
    end else begin
      if (d1[1:0] == 2'b01) begin
        a2 = {d1[31:10], va[19:12], 2'b00}; fetch_q.push_back({a2, 2'd1});
      end else begin
        a2 = {d1[31:12], va[19:10], 2'b00}; fetch_q.push_back({a2, 2'd2});
      end
      d2 = rd(a2);
      e.sz = d2[1:0];
      case (d2[1:0])
        2'b00: begin e.flt = 1'b1; e.lvl = 1'b1; end
        2'b01: begin e.pa = {d2[31:16], va[15:0]}; e.ap = d2[11:4]; end
        2'b10: begin e.pa = {d2[31:12], va[11:0]}; e.ap = d2[11:4]; end
        default: begin e.pa = {d2[31:10], va[9:0]}; e.ap = {4{d2[5:4]}}; end
      endcase
    end
    exp_q.push_back(e);
  endtask

  // memory responder
  logic        rsp_pend = 1'b0;
  int          rsp_cnt = 0;
  logic [31:0] rsp_addr = '0;
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (rsp_pend) begin
      if (rsp_cnt == 0) begin
        mem_rvalid = 1'b1; mem_rdata = rd(rsp_addr); rsp_pend = 1'b0;
      end else rsp_cnt--;
    end
    if (mem_req) begin
      rsp_pend = 1'b1; rsp_cnt = lat; rsp_addr = mem_addr;
    end
  end

  // fetch monitor
  always @(negedge clk) if (rst_n && mem_req) begin
    fetch_t f;
    if (fetch_q.size() == 0) chk(1'b0, "R10 unexpected fetch", mem_addr, 0);
    else begin
      f = fetch_q.pop_front();
      case (f.kind)
        2'd0: chk(mem_addr == f.addr, "R2 first-level address", mem_addr, f.addr);
        2'd1: chk(mem_addr == f.addr, "R5 coarse address", mem_addr, f.addr);
        default: chk(mem_addr == f.addr, "R6 fine address", mem_addr, f.addr);
      endcase
    end
  end

  // result monitor
  always @(negedge clk) if (rst_n && (done || fault)) begin
    exp_t e;
    if (exp_q.size() == 0) chk(1'b0, "R10 unexpected result", {done, fault}, 0);
    else begin
      e = exp_q.pop_front();
      chk(fault == e.flt && done == !e.flt, "R10 result kind", {done, fault}, {!e.flt, e.flt});
      if (e.flt) begin
        if (e.lvl) chk(flvl == 1'b1, "R9 second-level fault", flvl, 1);
        else       chk(flvl == 1'b0, "R3 first-level fault", flvl, 0);
      end else if (e.sz == 2'b00) begin
        chk({pa, size, dom, ap} == {e.pa, e.sz, e.dom, e.ap}, "R4 section result",
            {pa, size, dom, ap}, {e.pa, e.sz, e.dom, e.ap});
      end else begin
        chk({pa, size} == {e.pa, e.sz}, "R7 page address/size", {pa, size}, {e.pa, e.sz});
        chk({dom, ap} == {e.dom, e.ap}, "R8 page domain/ap", {dom, ap}, {e.dom, e.ap});
      end
    end
  end

  task automatic set_base(input logic [31:0] v);
    @(negedge clk); base_we = 1'b1; base_wdata = v;
    @(negedge clk); base_we = 1'b0;
    tb_base = v & 32'hFFFF_C000;
  endtask

  // mode 0 plain, 1 stray request while busy, 2 base write while busy
  task automatic walk(input logic [31:0] va, input int l, input int mode, input logic [31:0] nb);
    lat = l;
    predict(va);
    @(negedge clk); req_valid = 1'b1; req_va = va;
    @(negedge clk); req_valid = 1'b0;
    if (mode == 1) begin
      req_valid = 1'b1; req_va = 32'h1234_5678;
      @(negedge clk); req_valid = 1'b0;
    end else if (mode == 2) begin
      base_we = 1'b1; base_wdata = nb;
      @(negedge clk); base_we = 1'b0;
      tb_base = nb & 32'hFFFF_C000;
    end
    while (busy) @(negedge clk);
    chk(!done && !fault, "R10 pulse single-cycle", {done, fault}, 0);
    repeat (2) @(negedge clk);
    chk(!busy, "R10 stays idle", busy, 0);
  endtask

  task automatic run_all();
    repeat (2) @(negedge clk);
    chk({busy, done, fault, mem_req} == 4'b0, "R1 reset outputs", {busy, done, fault, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, fault, mem_req} == 4'b0, "R1 after release", {busy, done, fault, mem_req}, 0);

    // tables under base 0x0004_0000
    mem[32'h0004_0000 + 32'h123 * 4] = 32'hABC0_0000 | (2 << 10) | (5 << 5) | 2;
    mem[32'h0004_0000 + 32'h200 * 4] = 32'h0007_0400 | (3 << 5) | 1;
    mem[32'h0007_0400 + 32'h11 * 4]  = 32'h5555_0000 | (8'hE4 << 4) | 1;
    mem[32'h0007_0400 + 32'h22 * 4]  = 32'h6666_7000 | (8'h1B << 4) | 2;
    mem[32'h0007_0400 + 32'h33 * 4]  = 32'h7777_8C00 | (2 << 4) | 3;
    mem[32'h0004_0000 + 32'h300 * 4] = 32'h0009_3000 | (9 << 5) | 3;
    mem[32'h0009_3000 + 32'h3FF * 4] = 32'h1234_5400 | (1 << 4) | 3;
    mem[32'h0009_3000]               = 32'h0ABC_D000 | (8'h3C << 4) | 2;
    mem[32'h0009_3000 + 32'h115 * 4] = 32'hFEDC_0000 | (8'h81 << 4) | 1;
    // tables under base 0x0010_C000
    mem[32'h0010_C000 + 32'hFFF * 4] = 32'h8000_0000 | (1 << 10) | (15 << 5) | 2;

    set_base(32'h0004_0000);
    walk(32'h1234_5678, 0, 0, 0);  // R4 section
    walk(32'h0000_0000, 1, 0, 0);  // R3 fault at first level
    walk(32'h2001_1ABC, 2, 0, 0);  // R5 R7 R8 large via coarse
    walk(32'h2002_2345, 0, 1, 0);  // R7 small, R10 stray request ignored
    walk(32'h2003_3123, 3, 0, 0);  // R7 R8 tiny via coarse
    walk(32'h2004_4000, 1, 0, 0);  // R9 second-level fault
    walk(32'h300F_FE7F, 2, 0, 0);  // R6 fine, last index, tiny
    walk(32'h3000_0000, 0, 0, 0);  // R6 fine, index zero, small
    walk(32'h3004_5678, 4, 1, 0);  // R6 fine large
    walk(32'h1234_5678, 2, 2, 32'h0010_FFFF); // R2 base change mid-walk
    walk(32'h1234_5678, 1, 0, 0);  // R2 new base: unmapped -> R3
    walk(32'hFFF1_2345, 0, 0, 0);  // R2 top first-level index, R4
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all results seen", exp_q.size(), 0);
    chk(fetch_q.size() == 0, "R10 all fetches seen", fetch_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog actual=busy expected=idle");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule